// File: doc/BRIEF.md
# Privilege-filtered branch trace buffer

This block keeps a short history of taken branches. Each retired branch arrives on a single-cycle strobe. The strobe carries the source address, the destination address, a flag that says whether the branch was predicted correctly, and the privilege ring in which the branch ran. A two-bit select register can drop branches from ring 0, from the outer rings, or from both. Every branch that passes the filter moves a top-of-stack pointer forward by one. The record is then written into the slot that the pointer now names, so the pointer always marks the newest record.

Software reaches the block through one plain register port. A read returns its data one cycle later. The ring holds only the raw addresses and the flag. The canonical 64-bit form is built on the read path: the upper bits copy address bit 47, and in a source record bit 63 holds the prediction flag. The select register is the only location that software can write.

Top module: `brtrace_buf`

## Requirements
- R1: After reset the pointer reads 0, the select register reads 0, and every source and destination record reads 0.
- R2: With select = 0, every valid branch is captured, whatever its ring.
- R3: With select bit 0 set, a branch with ring = 0 is dropped.
- R4: With select bit 1 set, a branch with ring != 0 is dropped. The two bits act independently.
- R5: An accepted branch advances the pointer by one, wrapping from 15 to 0. Its record is stored at the new pointer value.
- R6: A dropped branch changes neither the pointer nor any record.
- R7: A source record reads as follows: the address in bits 47:0, copies of bit 47 in bits 62:48, and the prediction flag in bit 63 (1 = predicted correctly).
- R8: A destination record reads as follows: the target in bits 47:0 and copies of bit 47 in bits 63:48.
- R9: The register map is fixed. Addresses 0-15 hold the source records of slots 0-15, and addresses 16-31 hold the destination records. Address 32 holds the pointer in bits 3:0, and address 33 holds the select value in bits 1:0. All other bits and all other addresses read 0.
- R10: The read data updates on the clock edge that samples the read enable. It holds its value while no read is issued.
- R11: A write changes the select register only at address 33. A write to any other address leaves the records, the pointer and the select value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Retired taken branch present this cycle |
| br_from | input | 48 | Source linear address of the branch |
| br_to | input | 48 | Destination linear address of the branch |
| br_pred_ok | input | 1 | 1 when the branch was predicted correctly |
| br_ring | input | 2 | Privilege ring of the branch |
| reg_addr | input | 6 | Register address for reads and writes |
| reg_rd_en | input | 1 | Read strobe |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 2 | Write data (select value) |
| reg_rd_data | output | 64 | Registered read data |

## Verification
The bench uses the default build: 16 slots, 48-bit addresses and a 2-bit ring. This keeps the whole space small enough to sweep. Every one of the four select codes meets every one of the four rings. The pointer wraps more than twice, and address bit 47 takes both values in both record kinds. After each phase the bench reads back every address of the map and compares it with a model that keeps its own array.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
  localparam int SEL_W   = 2;
  localparam int SEL_SUP = 0;  // drop ring-0 branches
  localparam int SEL_USR = 1;  // drop outer-ring branches

  typedef enum logic [1:0] {
    RGN_FROM = 2'b00,
    RGN_TO   = 2'b01,
    RGN_CTL  = 2'b10,
    RGN_NONE = 2'b11
  } rgn_e;
endpackage

// File: rtl/brtrace_filter.sv
module brtrace_filter
  import brtrace_pkg::*;
#(
  parameter int RING_W = 2
) (
  input  logic              valid,
  input  logic [RING_W-1:0] ring,
  input  logic [SEL_W-1:0]  sel,
  output logic              accept
);
  logic drop_sup;
  logic drop_usr;

  always_comb begin
    drop_sup = sel[SEL_SUP] && (ring == '0);
    drop_usr = sel[SEL_USR] && (ring != '0);
    accept   = valid && !(drop_sup || drop_usr);
  end
endmodule

// File: rtl/brtrace_fmt.sv
module brtrace_fmt #(
  parameter int VA_W  = 48,
  parameter int REC_W = 64
) (
  input  logic             pred_ok,
  input  logic [VA_W-1:0]  from_va,
  input  logic [VA_W-1:0]  to_va,
  output logic [REC_W-1:0] from_rec,
  output logic [REC_W-1:0] to_rec
);
  localparam int FROM_EXT = REC_W - VA_W - 1;
  localparam int TO_EXT   = REC_W - VA_W;

  always_comb begin
    from_rec = {pred_ok, {FROM_EXT{from_va[VA_W-1]}}, from_va};
    to_rec   = {{TO_EXT{to_va[VA_W-1]}}, to_va};
  end
endmodule

// File: rtl/brtrace_store.sv
module brtrace_store #(
  parameter int DEPTH = 16,
  parameter int VA_W  = 48,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [VA_W-1:0]  push_from,
  input  logic [VA_W-1:0]  push_to,
  input  logic             push_pred,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VA_W-1:0]  rd_from,
  output logic [VA_W-1:0]  rd_to,
  output logic             rd_pred,
  output logic [IDX_W-1:0] tos_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] tos_d;
  logic [VA_W-1:0]  from_mem [DEPTH];
  logic [VA_W-1:0]  to_mem   [DEPTH];
  logic             pred_mem [DEPTH];
  logic [DEPTH-1:0] slot_we;

  always_comb begin
    tos_d = tos_q;
    if (push) tos_d = (tos_q == LAST) ? '0 : tos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tos_q <= '0;
    else if (push) tos_q <= tos_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_we[g] = push && (tos_d == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        from_mem[g] <= '0;
        to_mem[g]   <= '0;
        pred_mem[g] <= 1'b0;
      end else if (slot_we[g]) begin
        from_mem[g] <= push_from;
        to_mem[g]   <= push_to;
        pred_mem[g] <= push_pred;
      end
    end
  end

  logic idx_ok;
  assign idx_ok = {1'b0, rd_idx} < (IDX_W + 1)'(DEPTH);

  always_comb begin
    rd_from = idx_ok ? from_mem[rd_idx] : '0;
    rd_to   = idx_ok ? to_mem[rd_idx]   : '0;
    rd_pred = idx_ok ? pred_mem[rd_idx] : 1'b0;
  end
endmodule

// File: rtl/brtrace_buf.sv
module brtrace_buf
  import brtrace_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int VA_W   = 48,
  parameter int REC_W  = 64,
  parameter int RING_W = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [VA_W-1:0]   br_from,
  input  logic [VA_W-1:0]   br_to,
  input  logic              br_pred_ok,
  input  logic [RING_W-1:0] br_ring,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd_en,
  input  logic              reg_wr_en,
  input  logic [SEL_W-1:0]  reg_wr_data,
  output logic [REC_W-1:0]  reg_rd_data
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = {RGN_CTL, IDX_W'(1)};

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [REC_W-1:0] rd_q, rd_d, rd_next;
  logic             accept;
  logic [IDX_W-1:0] tos_q;
  logic [IDX_W-1:0] idx;
  rgn_e             rgn;
  logic [VA_W-1:0]  s_from, s_to;
  logic             s_pred;
  logic [REC_W-1:0] from_rec, to_rec;

  assign rgn = rgn_e'(reg_addr[ADDR_W-1 -: 2]);
  assign idx = reg_addr[IDX_W-1:0];

  brtrace_filter #(.RING_W(RING_W)) u_filter (
    .valid  (br_valid),
    .ring   (br_ring),
    .sel    (sel_q),
    .accept (accept)
  );

  brtrace_store #(.DEPTH(DEPTH), .VA_W(VA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_from (br_from),
    .push_to   (br_to),
    .push_pred (br_pred_ok),
    .rd_idx    (idx),
    .rd_from   (s_from),
    .rd_to     (s_to),
    .rd_pred   (s_pred),
    .tos_q     (tos_q)
  );

  brtrace_fmt #(.VA_W(VA_W), .REC_W(REC_W)) u_fmt (
    .pred_ok  (s_pred),
    .from_va  (s_from),
    .to_va    (s_to),
    .from_rec (from_rec),
    .to_rec   (to_rec)
  );

  always_comb begin
    sel_d = sel_q;
    if (reg_wr_en && (reg_addr == SEL_ADDR)) sel_d = reg_wr_data;
  end

  always_comb begin
    rd_next = '0;
    case (rgn)
      RGN_FROM: rd_next = from_rec;
      RGN_TO:   rd_next = to_rec;
      RGN_CTL: begin
        if (idx == IDX_W'(0))      rd_next = REC_W'(tos_q);
        else if (idx == IDX_W'(1)) rd_next = REC_W'(sel_q);
      end
      default:  rd_next = '0;
    endcase
    rd_d = reg_rd_en ? rd_next : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      rd_q  <= '0;
    end else begin
      sel_q <= sel_d;
      rd_q  <= rd_d;
    end
  end

  assign reg_rd_data = rd_q;
endmodule

// File: rtl/brtrace_buf_chk.sv
module brtrace_buf_chk #(
  parameter int DEPTH  = 16,
  parameter int VA_W   = 48,
  parameter int REC_W  = 64,
  parameter int RING_W = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic [RING_W-1:0] br_ring,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd_en,
  input logic              reg_wr_en,
  input logic [REC_W-1:0]  reg_rd_data,
  input logic [1:0]        sel_q,
  input logic [IDX_W-1:0]  tos_q
);
  localparam logic [ADDR_W-1:0] SEL_A = {2'b10, IDX_W'(1)};
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(DEPTH - 1);

  logic blocked;
  assign blocked = (br_ring == '0) ? sel_q[0] : sel_q[1];

  a_r5_tos_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !blocked) |=>
      tos_q == (($past(tos_q) == LAST) ? '0 : $past(tos_q) + 1'b1));

  a_r6_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && blocked) |=> $stable(tos_q));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(tos_q));

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rd_data));

  a_r7_from_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr[ADDR_W-1 -: 2] == 2'b00) |=>
      reg_rd_data[REC_W-2:VA_W] == {(REC_W-VA_W-1){reg_rd_data[VA_W-1]}});

  a_r8_to_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr[ADDR_W-1 -: 2] == 2'b01) |=>
      reg_rd_data[REC_W-1:VA_W] == {(REC_W-VA_W){reg_rd_data[VA_W-1]}});

  a_r9_sel_width: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == SEL_A) |=> reg_rd_data[REC_W-1:2] == '0);

  a_r11_sel_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr_en && reg_addr == SEL_A)) |=> $stable(sel_q));
endmodule

bind brtrace_buf brtrace_buf_chk #(
  .DEPTH(DEPTH), .VA_W(VA_W), .REC_W(REC_W), .RING_W(RING_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .br_valid    (br_valid),
  .br_ring     (br_ring),
  .reg_addr    (reg_addr),
  .reg_rd_en   (reg_rd_en),
  .reg_wr_en   (reg_wr_en),
  .reg_rd_data (reg_rd_data),
  .sel_q       (sel_q),
  .tos_q       (tos_q)
);

// File: tb/brtrace_buf_bench.sv
`timescale 1ns/1ps
module brtrace_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid;
  logic [47:0] br_from, br_to;
  logic        br_pred_ok;
  logic [1:0]  br_ring;
  logic [5:0]  reg_addr;
  logic        reg_rd_en, reg_wr_en;
  logic [1:0]  reg_wr_data;
  logic [63:0] reg_rd_data;

  int total = 0;
  int bad   = 0;

  logic [47:0] m_from [16];
  logic [47:0] m_to   [16];
  logic        m_pred [16];
  int          m_tos;
  logic [1:0]  m_sel;

  always #2 clk = ~clk;

  brtrace_buf u_brtrace_buf (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_from(br_from),
    .br_to(br_to), .br_pred_ok(br_pred_ok), .br_ring(br_ring),
    .reg_addr(reg_addr), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mk_va(input int k, input int salt);
    logic [47:0] a;
    a = 48'(64'(k + salt * 1000) * 64'h0000_9E37_79B9_7F4B);
    a[47] = k[0] ^ salt[0];
    return a;
  endfunction

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rd_data;
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] d);
    @(negedge clk);
    reg_addr    = a;
    reg_wr_data = d;
    reg_wr_en   = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a == 6'd33) m_sel = d;
  endtask

  task automatic branch(input int k, input logic [1:0] ring);
    logic keep;
    @(negedge clk);
    br_valid   = 1'b1;
    br_from    = mk_va(k, 1);
    br_to      = mk_va(k, 2);
    br_pred_ok = k[1];
    br_ring    = ring;
    keep = (ring == 2'd0) ? !m_sel[0] : !m_sel[1];
    if (keep) begin
      m_tos = (m_tos + 1) % 16;
      m_from[m_tos] = br_from;
      m_to[m_tos]   = br_to;
      m_pred[m_tos] = br_pred_ok;
    end
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic dump_all(input string tag);
    logic [63:0] d;
    for (int i = 0; i < 16; i++) begin
      rd(6'(i), d);
      chk(d, {m_pred[i], {15{m_from[i][47]}}, m_from[i]}, {tag, " R7 src"});
      rd(6'(16 + i), d);
      chk(d, {{16{m_to[i][47]}}, m_to[i]}, {tag, " R8 dst"});
    end
    rd(6'd32, d);
    chk(d, 64'(m_tos), {tag, " R9 tos"});
    rd(6'd33, d);
    chk(d, 64'(m_sel), {tag, " R9 sel"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d, hold;
    string tg;
    rst_n = 1'b0; br_valid = 1'b0; br_from = '0; br_to = '0; br_pred_ok = 1'b0;
    br_ring = '0; reg_addr = '0; reg_rd_en = 1'b0; reg_wr_en = 1'b0; reg_wr_data = '0;
    for (int i = 0; i < 16; i++) begin m_from[i] = '0; m_to[i] = '0; m_pred[i] = 1'b0; end
    m_tos = 0; m_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of the full map
    dump_all("R1");
    for (int a = 34; a < 64; a++) begin
      rd(6'(a), d);
      chk(d, 64'd0, "R9 unmapped");
    end

    // R2 R3 R4: every select code against every ring
    for (int s = 0; s < 4; s++) begin
      wr(6'd33, 2'(s));
      for (int r = 0; r < 4; r++) begin
        for (int k = 0; k < 3; k++) branch(s * 40 + r * 8 + k, 2'(r));
        tg = (s == 0) ? "R2" : ((r == 0) ? "R3" : "R4");
        rd(6'd32, d);
        chk(d, 64'(m_tos), {tg, " filter pointer"});
      end
      dump_all((s == 0) ? "R2" : "R4");
    end

    // R11: writes outside the select address
    wr(6'd33, 2'd0);
    wr(6'd0, 2'd3);
    wr(6'd17, 2'd3);
    wr(6'd32, 2'd2);
    wr(6'd40, 2'd1);
    dump_all("R11");

    // R5: wrap the pointer repeatedly
    for (int k = 0; k < 40; k++) begin
      branch(500 + k, 2'(k % 4));
      rd(6'd32, d);
      chk(d, 64'(m_tos), "R5 wrap");
    end
    dump_all("R5");

    // R6: everything dropped
    wr(6'd33, 2'd3);
    for (int k = 0; k < 8; k++) branch(700 + k, 2'(k % 4));
    dump_all("R6");

    // R10: read data holds without a read strobe
    wr(6'd33, 2'd0);
    rd(6'(m_tos), hold);
    chk(hold, {m_pred[m_tos], {15{m_from[m_tos][47]}}, m_from[m_tos]}, "R10 read");
    for (int k = 0; k < 20; k++) branch(800 + k, 2'd1);
    @(negedge clk);
    chk(reg_rd_data, hold, "R10 hold");
    dump_all("R10");

    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) begin m_from[i] = '0; m_to[i] = '0; m_pred[i] = 1'b0; end
    m_tos = 0; m_sel = '0;
    @(negedge clk);
    chk(reg_rd_data, 64'd0, "R1 rd data");
    rst_n = 1'b1;
    dump_all("R1 again");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule